// File: doc/BRIEF.md
# Packed-BCD Capable 8-bit Adder with Flag Generation

This block is the addition datapath of a small accumulator CPU. It sums two 8-bit operands as a plain add, as an add that folds in the stored carry, or as the add of the second accumulator into the first. It produces the result together with five status flags: half carry, negative, zero, overflow and carry. A fourth operation, decimal adjust, takes a byte that came out of a binary add of two packed-BCD bytes. Using the stored half-carry and carry, it corrects that byte into two valid decimal digits.

The sum and the flags are formed combinationally and then captured in one output register stage. For each accepted operation, the register presents the result, the new flag values and a per-flag write-enable mask. The CPU's condition register commits only the flags whose enable is set, one cycle after the operation was offered. Half carry is written only by the three add operations. Decimal adjust reads the half-carry and carry but never writes the half-carry.

Top module: `bcd_adder_unit`

## Requirements
- R1: Operation code on `op_sel_i`: 0 plain add, 1 add with carry, 2 second accumulator into first, 3 decimal adjust. For codes 0 and 2 the result is (A+B) mod 256. For code 1 it is (A+B+carry_i) mod 256.
- R2: For the three add operations, the carry flag equals the carry out of bit 7 of the sum.
- R3: For the three add operations, the half-carry flag equals the carry out of bit 3. Decimal adjust leaves it unwritten (enable bit 4 low) and passes `half_i` through on bit 4.
- R4: For the three add operations, overflow is set only when A and B have equal bit 7 and the result's bit 7 differs from it. Decimal adjust writes overflow as 0.
- R5: For every operation, negative equals result bit 7 and zero is set exactly when the 8-bit result is 0.
- R6: Decimal adjust works on A alone. It adds 0x06 when A's low nibble exceeds 9 or `half_i` is 1. It adds 0x60 when A's high nibble exceeds 9, when `carry_i` is 1, or when the high nibble is 9 and the low nibble exceeds 9. The result is the sum mod 256.
- R7: Decimal adjust sets the carry flag exactly when the 0x60 correction is applied. After a plain add of two packed-BCD bytes x and y followed by decimal adjust, the result is the BCD form of (x+y) mod 100 and the carry is set exactly when x+y ≥ 100.
- R8: Outputs are registered. An operation offered with `op_valid_i` high appears one clock later with `res_valid_o` high. When `op_valid_i` is low, the next cycle shows `res_valid_o` low and `flag_we_o` all zero, and `result_o` keeps its value.
- R9: Synchronous active-high reset clears `res_valid_o`, `result_o`, `flags_o` and `flag_we_o` to zero.
- R10: Flag bit positions in `flags_o` and `flag_we_o`: 4 half carry, 3 negative, 2 zero, 1 overflow, 0 carry. Add operations drive the enable mask 5'b11111 and decimal adjust drives 5'b01111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation offered this cycle |
| op_sel_i | input | 2 | Operation code (R1) |
| opnd_a_i | input | 8 | First accumulator / adjust source |
| opnd_b_i | input | 8 | Second operand |
| carry_i | input | 1 | Stored carry flag |
| half_i | input | 1 | Stored half-carry flag |
| res_valid_o | output | 1 | Registered result valid |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | New flag values (R10 order) |
| flag_we_o | output | 5 | Per-flag write enables (R10 order) |

## Verification
A wrong nibble carry or a broken correction chain shows up as a wrong digit in `result_o`, or as a wrong H or C bit. It appears in the very next cycle after the faulty operation, since there is only one register stage. The bench compares every field against an arithmetic model while it sweeps operand pairs with every carry and half-carry combination. It also chains a plain add into a decimal adjust for all pairs of two-digit decimal values, so a misplaced digit fix shows up as a wrong decimal sum. A stuck write enable or a missed hold of the result is visible in the cycle after an idle input.

// File: rtl/bcdalu_pkg.sv
package bcdalu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADC  = 2'd1,
    OP_ACC  = 2'd2,
    OP_DADJ = 2'd3
  } op_e;

  localparam int FLAG_W = 5;
  localparam int FL_H = 4;
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_V = 1;
  localparam int FL_C = 0;

  localparam logic [FLAG_W-1:0] WE_ADD  = 5'b11111;
  localparam logic [FLAG_W-1:0] WE_DADJ = 5'b01111;
endpackage

// File: rtl/bcdalu_nibble_add.sv
module bcdalu_nibble_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] tot;
  assign tot = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
  assign s_o = tot[W-1:0];
  assign c_o = tot[W];
endmodule

// File: rtl/bcdalu_bin_adder.sv
// Binary adder built as a ripple of digit-wide cells; exposes the digit-0
// carry (half carry, R3), the top carry (R2) and signed overflow (R4).
module bcdalu_bin_adder #(
  parameter int WIDTH   = 8,
  parameter int DIGIT_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             half_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int DIGITS = WIDTH / DIGIT_W;

  logic [DIGITS:0] cy;
  assign cy[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcdalu_nibble_add #(.W(DIGIT_W)) add_i (
      .a_i (a_i[g*DIGIT_W +: DIGIT_W]),
      .b_i (b_i[g*DIGIT_W +: DIGIT_W]),
      .c_i (cy[g]),
      .s_o (sum_o[g*DIGIT_W +: DIGIT_W]),
      .c_o (cy[g+1])
    );
  end

  assign half_o  = cy[1];
  assign carry_o = cy[DIGITS];
  assign ovf_o   = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/bcdalu_digit_fix.sv
// One decimal digit of the adjust chain: absorbs the carry of the digit
// below, adds 6 when the digit is out of range or forced by a stored flag.
module bcdalu_digit_fix #(
  parameter bit TOP = 1'b0
) (
  input  logic [3:0] d_i,
  input  logic       cin_i,
  input  logic       force_i,
  output logic [3:0] d_o,
  output logic       cout_o
);
  logic [4:0] pre;
  logic [4:0] post;
  logic       fix;

  assign pre  = {1'b0, d_i} + {4'b0000, cin_i};
  assign fix  = (pre > 5'd9) || force_i;
  assign post = pre + (fix ? 5'd6 : 5'd0);
  assign d_o  = post[3:0];

  if (TOP) begin : g_top
    assign cout_o = fix | post[4];
  end else begin : g_low
    assign cout_o = post[4];
  end
endmodule

// File: rtl/bcdalu_dadj.sv
// Decimal adjust (R6, R7): lowest digit forced by half carry, top digit by carry.
module bcdalu_dadj #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic             half_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o
);
  localparam int DIGITS = WIDTH / 4;

  logic [DIGITS:0]   cy;
  logic [DIGITS-1:0] frc;
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_fix
    if (g == 0) begin : g_f0
      assign frc[g] = half_i;
    end else if (g == DIGITS - 1) begin : g_ft
      assign frc[g] = carry_i;
    end else begin : g_fm
      assign frc[g] = 1'b0;
    end

    bcdalu_digit_fix #(.TOP(g == DIGITS - 1)) fix_i (
      .d_i     (acc_i[g*4 +: 4]),
      .cin_i   (cy[g]),
      .force_i (frc[g]),
      .d_o     (acc_o[g*4 +: 4]),
      .cout_o  (cy[g+1])
    );
  end

  assign carry_o = cy[DIGITS];
endmodule

// File: rtl/bcdalu_flag_gen.sv
// Assembles the flag vector and its write mask (R3, R4, R5, R10).
module bcdalu_flag_gen
  import bcdalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  op_e               op_i,
  input  logic [WIDTH-1:0]  res_i,
  input  logic              add_half_i,
  input  logic              add_carry_i,
  input  logic              add_ovf_i,
  input  logic              adj_carry_i,
  input  logic              half_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] we_o
);
  always_comb begin
    flags_o[FL_N] = res_i[WIDTH-1];
    flags_o[FL_Z] = (res_i == '0);
    if (op_i == OP_DADJ) begin
      flags_o[FL_H] = half_i;
      flags_o[FL_V] = 1'b0;
      flags_o[FL_C] = adj_carry_i;
      we_o          = WE_DADJ;
    end else begin
      flags_o[FL_H] = add_half_i;
      flags_o[FL_V] = add_ovf_i;
      flags_o[FL_C] = add_carry_i;
      we_o          = WE_ADD;
    end
  end
endmodule

// File: rtl/bcd_adder_unit.sv
module bcd_adder_unit
  import bcdalu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid_i,
  input  logic [1:0]       op_sel_i,
  input  logic [WIDTH-1:0] opnd_a_i,
  input  logic [WIDTH-1:0] opnd_b_i,
  input  logic             carry_i,
  input  logic             half_i,
  output logic             res_valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic [4:0]       flags_o,
  output logic [4:0]       flag_we_o
);
  op_e               op;
  logic              add_cin;
  logic [WIDTH-1:0]  add_sum;
  logic              add_half, add_carry, add_ovf;
  logic [WIDTH-1:0]  adj_res;
  logic              adj_carry;
  logic [WIDTH-1:0]  res_d;
  logic [FLAG_W-1:0] flags_d, we_d;

  assign op      = op_e'(op_sel_i);
  assign add_cin = (op == OP_ADC) ? carry_i : 1'b0;   // R1

  bcdalu_bin_adder #(.WIDTH(WIDTH), .DIGIT_W(4)) add_i (
    .a_i     (opnd_a_i),
    .b_i     (opnd_b_i),
    .cin_i   (add_cin),
    .sum_o   (add_sum),
    .half_o  (add_half),
    .carry_o (add_carry),
    .ovf_o   (add_ovf)
  );

  bcdalu_dadj #(.WIDTH(WIDTH)) adj_i (
    .acc_i   (opnd_a_i),
    .half_i  (half_i),
    .carry_i (carry_i),
    .acc_o   (adj_res),
    .carry_o (adj_carry)
  );

  assign res_d = (op == OP_DADJ) ? adj_res : add_sum;

  bcdalu_flag_gen #(.WIDTH(WIDTH)) flg_i (
    .op_i        (op),
    .res_i       (res_d),
    .add_half_i  (add_half),
    .add_carry_i (add_carry),
    .add_ovf_i   (add_ovf),
    .adj_carry_i (adj_carry),
    .half_i      (half_i),
    .flags_o     (flags_d),
    .we_o        (we_d)
  );

  // Output register stage (R8, R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
      flag_we_o   <= '0;
    end else begin
      res_valid_o <= op_valid_i;
      if (op_valid_i) begin
        result_o  <= res_d;
        flags_o   <= flags_d;
        flag_we_o <= we_d;
      end else begin
        flag_we_o <= '0;
      end
    end
  end
endmodule

// File: rtl/bcd_adder_unit_chk.sv
module bcd_adder_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid_i,
  input logic [1:0]       op_sel_i,
  input logic [WIDTH-1:0] opnd_a_i,
  input logic [WIDTH-1:0] opnd_b_i,
  input logic             carry_i,
  input logic             half_i,
  input logic             res_valid_o,
  input logic [WIDTH-1:0] result_o,
  input logic [4:0]       flags_o,
  input logic [4:0]       flag_we_o
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> res_valid_o);
  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!res_valid_o && flag_we_o == 5'b0));
  p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> $stable(result_o));
  p_neg_bit_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> flags_o[3] == result_o[WIDTH-1]);
  p_zero_bit_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> flags_o[2] == (result_o == '0));
  p_half_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_sel_i == 2'd3) |=> (!flag_we_o[4] && flags_o[4] == $past(half_i)));
  p_adj_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_sel_i == 2'd3 && carry_i) |=> flags_o[0]);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_sel_i != 2'd3 && opnd_a_i[WIDTH-1] != opnd_b_i[WIDTH-1]) |=> !flags_o[1]);
endmodule

bind bcd_adder_unit bcd_adder_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .op_valid_i  (op_valid_i),
  .op_sel_i    (op_sel_i),
  .opnd_a_i    (opnd_a_i),
  .opnd_b_i    (opnd_b_i),
  .carry_i     (carry_i),
  .half_i      (half_i),
  .res_valid_o (res_valid_o),
  .result_o    (result_o),
  .flags_o     (flags_o),
  .flag_we_o   (flag_we_o)
);

// File: tb/bcd_adder_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_adder_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid_i = 1'b0;
  logic [1:0] op_sel_i = 2'd0;
  logic [7:0] opnd_a_i = 8'd0;
  logic [7:0] opnd_b_i = 8'd0;
  logic       carry_i = 1'b0;
  logic       half_i = 1'b0;
  logic       res_valid_o;
  logic [7:0] result_o;
  logic [4:0] flags_o;
  logic [4:0] flag_we_o;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_adder_unit #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_sel_i(op_sel_i),
    .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .carry_i(carry_i), .half_i(half_i),
    .res_valid_o(res_valid_o), .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Arithmetic reference: flags {H,N,Z,V,C}
  task automatic model(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic h,
                       output logic [7:0] r, output logic [4:0] f, output logic [4:0] we);
    int s, lo, hi, adj, cin;
    logic cf, hf, vf;
    if (op != 2'd3) begin
      cin = (op == 2'd1) ? int'(c) : 0;
      s   = int'(a) + int'(b) + cin;
      r   = s[7:0];
      hf  = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
      cf  = s > 255;
      vf  = (a[7] == b[7]) && (r[7] != a[7]);
      we  = 5'b11111;
    end else begin
      lo = int'(a) % 16; hi = int'(a) / 16; adj = 0; cf = 1'b0;
      if (lo > 9 || h) adj += 6;
      if (hi > 9 || c || (hi == 9 && lo > 9)) begin adj += 96; cf = 1'b1; end
      s  = int'(a) + adj;
      r  = s[7:0];
      hf = h; vf = 1'b0;
      we = 5'b01111;
    end
    f = {hf, r[7], (r == 8'd0), vf, cf};
  endtask

  // Drive one operation (at negedge), check it at the next negedge.
  task automatic apply(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic h,
                       output logic [7:0] r, output logic [4:0] f);
    logic [4:0] we;
    model(op, a, b, c, h, r, f, we);
    op_valid_i = 1'b1; op_sel_i = op; opnd_a_i = a; opnd_b_i = b; carry_i = c; half_i = h;
    @(negedge clk);
    vectors++;
    cmp((op == 2'd3) ? "R6 result" : "R1 result", int'(result_o), int'(r));
    cmp((op == 2'd3) ? "R7 carry" : "R2 carry", int'(flags_o[0]), int'(f[0]));
    cmp("R3 half", int'(flags_o[4]), int'(f[4]));
    cmp("R4 overflow", int'(flags_o[1]), int'(f[1]));
    cmp("R5 neg/zero", int'(flags_o[3:2]), int'(f[3:2]));
    cmp("R10 write mask", int'(flag_we_o), int'(we));
    cmp("R8 valid", int'(res_valid_o), 1);
  endtask

  task automatic idle_check(input logic [7:0] held);
    op_valid_i = 1'b0; op_sel_i = 2'd1; opnd_a_i = 8'hFF; opnd_b_i = 8'h01; carry_i = 1'b1;
    @(negedge clk);
    vectors++;
    cmp("R8 idle valid", int'(res_valid_o), 0);
    cmp("R8 idle write mask", int'(flag_we_o), 0);
    cmp("R8 idle result hold", int'(result_o), int'(held));
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    logic [4:0] f, f2;
    repeat (3) @(negedge clk);
    // R9: reset state
    vectors++;
    cmp("R9 reset valid", int'(res_valid_o), 0);
    cmp("R9 reset result", int'(result_o), 0);
    cmp("R9 reset flags", int'(flags_o), 0);
    cmp("R9 reset write mask", int'(flag_we_o), 0);
    rst = 1'b0;

    // R1..R5, R10: add variants, all a, strided b, carry/half inputs toggled
    for (int op = 0; op < 3; op++) begin
      for (int cv = 0; cv < 2; cv++) begin
        if (op != 1 && cv == 1) continue;
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b += 7) begin
            apply(2'(op), 8'(a), 8'(b), 1'(cv), 1'(b & 1), r, f);
          end
        end
      end
    end
    // Edge operands: wrap to zero, max carry chain, signed overflow
    apply(2'd0, 8'hFF, 8'h01, 1'b0, 1'b0, r, f);
    apply(2'd1, 8'hFF, 8'hFF, 1'b1, 1'b0, r, f);
    apply(2'd2, 8'h7F, 8'h01, 1'b0, 1'b1, r, f);
    apply(2'd0, 8'h80, 8'h80, 1'b0, 1'b0, r, f);
    // R8: idle cycle holds the result and writes nothing
    idle_check(r);
    idle_check(r);

    // R6, R7, R3: decimal adjust over all bytes and flag inputs
    for (int a = 0; a < 256; a++) begin
      for (int fl = 0; fl < 4; fl++) begin
        apply(2'd3, 8'(a), 8'(255 - a), 1'(fl >> 1), 1'(fl & 1), r, f);
      end
    end

    // R7: BCD add then adjust gives the decimal sum
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        apply(2'd0, to_bcd(x), to_bcd(y), 1'b0, 1'b0, r, f);
        apply(2'd3, r, 8'h00, f[0], f[4], r2, f2);
        cmp("R7 decimal sum", int'(result_o), int'(to_bcd((x + y) % 100)));
        cmp("R7 decimal carry", int'(flags_o[0]), int'((x + y) >= 100));
      end
    end
    idle_check(to_bcd(98));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule